// File: doc/BRIEF.md
# Bus Data-Beat and Termination Sequencer

This block handles the data phase of a 64-bit system bus on the slave side. It accepts one transfer request at a time. The request states how much data moves and whether the memory behind the slave is 64 or 32 bits wide. The block cuts the transfer into port-sized beats and paces each beat with a ready input from the memory side. It reports every beat with a data-valid strobe. A separate acknowledge strobe marks the points at which the bus master may treat a transfer, or one double word of a burst, as finished.

Per-beat valid and termination acknowledge are kept apart. A wide transfer to a narrow port therefore shows several valid beats but acknowledges only at the doubleword or transfer end. A bus-monitor timer watches for a memory side that stops answering. It ends such a transfer with a one-cycle error strobe, and no acknowledge is given. Every beat driven onto the bus carries eight parity bits, one for each byte lane.

Top module: `beat_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_dval`, `bus_ta` and `bus_tea` are low.
- R2: A transfer needs a number of beats set by `req_size` (2'b00 one double word, 2'b01 two double words, 2'b10 or 2'b11 a burst of four double words) and by `req_narrow` (0 = 64-bit port, one beat per double word; 1 = 32-bit port, two beats per double word). Single takes 1 or 2 beats, double takes 2 or 4, and burst takes 4 or 8. `bus_dval` pulses once per beat.
- R3: Whenever `bus_ta` is high, `bus_dval` is high in the same cycle.
- R4: For a single or double transfer, `bus_ta` is asserted only on the final beat.
- R5: For a burst, `bus_ta` is asserted on the beat that completes each double word. That is every beat on a 64-bit port and every second beat on a 32-bit port, so the master sees four acknowledges.
- R6: A beat completes only in a busy cycle where `mem_ready` is high, and its strobes appear in the next cycle. Cycles with `mem_ready` low add no strobes.
- R7: After `TIMEOUT_CYC` consecutive busy cycles with `mem_ready` low, `bus_tea` pulses for one cycle and the block returns to idle without `bus_ta`. Each completed beat restarts the count.
- R8: `bus_tea` and `bus_ta` are never high in the same cycle.
- R9: A request is taken only when idle. `req_valid` during a transfer is dropped and adds no beats.
- R10: On each beat, `bus_dp[n]` is set so that `bus_data[8n+7:8n]` together with `bus_dp[n]` holds an odd number of ones.
- R11: On each beat, `bus_data` equals the `mem_rdata` value present in the cycle that completed the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_size | input | 2 | Transfer size: 00 single, 01 double, 1x burst |
| req_narrow | input | 1 | 1 = 32-bit memory port, 0 = 64-bit |
| mem_ready | input | 1 | Memory side completes a beat this cycle |
| mem_rdata | input | 64 | Data from the memory side |
| bus_dval | output | 1 | One data beat valid on the bus |
| bus_ta | output | 1 | Transfer / doubleword termination acknowledge |
| bus_tea | output | 1 | Error acknowledge from the bus monitor |
| bus_data | output | 64 | Data beat driven on the bus |
| bus_dp | output | 8 | Odd parity per byte lane of `bus_data` |

## Verification
Each size is run on both port widths. The acknowledge position per beat is recorded as a bitmask, so ack-on-last-only can be told apart from ack-per-doubleword and from ack-every-second-beat. Ready gaps of 0 to 7 idle cycles show that wait states stretch beats without adding strobes. A gap of exactly one cycle below the timeout must complete, while a gap equal to it must raise an error. Runs where the memory side stops after some beats separate a mid-transfer error from a clean end, and a request raised mid-transfer shows it is neither queued nor merged.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;

   localparam logic [1:0] SZ_SINGLE = 2'b00;
   localparam logic [1:0] SZ_DOUBLE = 2'b01;
   localparam logic [1:0] SZ_BURST  = 2'b10;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } seq_state_e;

endpackage

// File: rtl/beat_plan.sv
module beat_plan #(
   parameter int BURST_DW = 4,
   localparam int MAX_BEATS = BURST_DW * 2,
   localparam int BW = $clog2(MAX_BEATS)
) (
   input  logic [1:0]    size,
   input  logic          narrow,
   input  logic [BW-1:0] beat,
   output logic          last,
   output logic          ack
);
   import beat_seq_pkg::*;

   logic [BW:0] dwords;
   logic [BW:0] total;
   logic        burst;
   logic        dw_end;

   always_comb begin
      burst = size[1];
      if (burst)                 dwords = (BW+1)'(BURST_DW);
      else if (size == SZ_DOUBLE) dwords = (BW+1)'(2);
      else                       dwords = (BW+1)'(1);
      total  = narrow ? (dwords << 1) : dwords;
      last   = (({1'b0, beat} + (BW+1)'(1)) == total);
      dw_end = narrow ? beat[0] : 1'b1;
      ack    = last | (burst & dw_end);
   end

endmodule

// File: rtl/bus_monitor.sv
module bus_monitor #(
   parameter int TIMEOUT_CYC = 16,
   localparam int CW = $clog2(TIMEOUT_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   logic [CW-1:0] cnt_q;

   assign expire = run & ~kick & (cnt_q == CW'(TIMEOUT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || kick || expire) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
   end

endmodule

// File: rtl/lane_parity.sv
module lane_parity #(
   parameter int DATA_W  = 64,
   parameter bit REG_OUT = 1'b1,
   localparam int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d_next,
   input  logic [DATA_W-1:0] d_cur,
   output logic [LANES-1:0]  dp
);
   function automatic logic [LANES-1:0] odd_par(input logic [DATA_W-1:0] d);
      logic [LANES-1:0] p;
      for (int n = 0; n < LANES; n++) p[n] = ~(^d[8*n +: 8]);
      return p;
   endfunction

   generate
      if (REG_OUT) begin : g_reg
         logic [LANES-1:0] dp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dp_q <= {LANES{1'b1}};
            else if (load) dp_q <= odd_par(d_next);
         end
         assign dp = dp_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, load, d_next};
         assign dp = odd_par(d_cur);
      end
   endgenerate

endmodule

// File: rtl/beat_seq_top.sv
module beat_seq_top #(
   parameter int DATA_W      = 64,
   parameter int BURST_DW    = 4,
   parameter int TIMEOUT_CYC = 16,
   parameter bit REG_PARITY  = 1'b1,
   localparam int LANES      = DATA_W / 8,
   localparam int BW         = $clog2(BURST_DW * 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_size,
   input  logic              req_narrow,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              bus_dval,
   output logic              bus_ta,
   output logic              bus_tea,
   output logic [DATA_W-1:0] bus_data,
   output logic [LANES-1:0]  bus_dp
);
   import beat_seq_pkg::*;

   generate
      if (DATA_W % 16 != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 16");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (BURST_DW < 2) begin : g_bad_burst
         $error("BURST_DW must be at least 2");
      end
   endgenerate

   seq_state_e        state_q;
   logic [1:0]        size_q;
   logic              narrow_q;
   logic [BW-1:0]     beat_q;
   logic              dval_q, ta_q, tea_q;
   logic [DATA_W-1:0] data_q;
   logic              busy, last, ack, expire, take;

   assign busy = (state_q == ST_BUSY);
   assign take = busy & mem_ready;

   beat_plan #(.BURST_DW(BURST_DW)) u_plan (
      .size   (size_q),
      .narrow (narrow_q),
      .beat   (beat_q),
      .last   (last),
      .ack    (ack)
   );

   bus_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .kick   (mem_ready),
      .expire (expire)
   );

   lane_parity #(.DATA_W(DATA_W), .REG_OUT(REG_PARITY)) u_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take),
      .d_next (mem_rdata),
      .d_cur  (data_q),
      .dp     (bus_dp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         size_q   <= SZ_SINGLE;
         narrow_q <= 1'b0;
         beat_q   <= '0;
         dval_q   <= 1'b0;
         ta_q     <= 1'b0;
         tea_q    <= 1'b0;
         data_q   <= '0;
      end else begin
         dval_q <= 1'b0;
         ta_q   <= 1'b0;
         tea_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  size_q   <= req_size;
                  narrow_q <= req_narrow;
                  beat_q   <= '0;
                  state_q  <= ST_BUSY;
               end
            end
            default: begin
               if (mem_ready) begin
                  dval_q <= 1'b1;
                  ta_q   <= ack;
                  data_q <= mem_rdata;
                  if (last) state_q <= ST_IDLE;
                  else      beat_q  <= beat_q + BW'(1);
               end else if (expire) begin
                  tea_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign bus_dval = dval_q;
   assign bus_ta   = ta_q;
   assign bus_tea  = tea_q;
   assign bus_data = data_q;

   // R3: termination never without a valid beat
   p_ta_with_dval_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ta |-> bus_dval);

   // R8: error and acknowledge mutually exclusive
   p_ta_tea_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ta && bus_tea));

   // R6: a beat strobe follows a ready cycle while busy
   p_dval_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_dval) |-> $past(mem_ready) && $past(busy));

   // R7: an error strobe follows a busy cycle without ready
   p_tea_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_tea |-> $past(busy) && !$past(mem_ready));

   // R7: after an error the sequencer sits idle
   p_idle_after_tea_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_tea |-> !busy);

   // R9: a busy cycle without ready or timeout keeps the beat index
   p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ready && !expire |=> busy && $stable(beat_q));

endmodule

// File: tb/tb_beat_seq_top.sv
module tb_beat_seq_top;
   localparam int TMO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_narrow = 1'b0;
   logic        mem_ready = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        bus_dval, bus_ta, bus_tea;
   logic [63:0] bus_data;
   logic [7:0]  bus_dp;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2ns clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   beat_seq_top #(.TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
      .req_narrow(req_narrow), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .bus_dval(bus_dval), .bus_ta(bus_ta), .bus_tea(bus_tea),
      .bus_data(bus_data), .bus_dp(bus_dp));

   // {size[2], narrow[1], gap[4], nserve[4] (15 = unlimited), exp_dv[4], exp_ta[8], exp_tea[1]}
   localparam int NV = 11;
   localparam logic [23:0] VEC [NV] = '{
      {2'd0, 1'b0, 4'd0, 4'd15, 4'd1, 8'h01, 1'b0},  // single wide
      {2'd0, 1'b1, 4'd0, 4'd15, 4'd2, 8'h02, 1'b0},  // single narrow
      {2'd1, 1'b0, 4'd1, 4'd15, 4'd2, 8'h02, 1'b0},  // double wide, waits
      {2'd1, 1'b1, 4'd0, 4'd15, 4'd4, 8'h08, 1'b0},  // double narrow
      {2'd2, 1'b0, 4'd0, 4'd15, 4'd4, 8'h0F, 1'b0},  // burst wide
      {2'd2, 1'b1, 4'd2, 4'd15, 4'd8, 8'hAA, 1'b0},  // burst narrow, waits
      {2'd2, 1'b1, 4'd7, 4'd15, 4'd8, 8'hAA, 1'b0},  // gap just under timeout
      {2'd0, 1'b0, 4'd8, 4'd15, 4'd0, 8'h00, 1'b1},  // gap equal to timeout
      {2'd2, 1'b0, 4'd0, 4'd2,  4'd2, 8'h03, 1'b1},  // memory stops mid-burst
      {2'd1, 1'b1, 4'd3, 4'd3,  4'd3, 8'h00, 1'b1},  // stops before final beat
      {2'd3, 1'b1, 4'd0, 4'd15, 4'd8, 8'hAA, 1'b0}   // size 11 acts as burst
   };

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_par(input logic [63:0] d);
      logic [7:0] p;
      for (int n = 0; n < 8; n++) p[n] = ~(^d[8*n +: 8]);
      return p;
   endfunction

   task automatic run_xfer(input logic [1:0] sz, input logic nar, input int gap,
                           input int nserve, input int poke,
                           output int dv, output logic [7:0] tam, output int tea);
      int served = 0;
      logic [63:0] prev_rd = '0;
      int window = 8 * (gap + 1) + TMO + 4;
      dv = 0; tam = '0; tea = 0;
      @(negedge clk);
      req_valid = 1'b1; req_size = sz; req_narrow = nar;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < window; k++) begin
         mem_ready = (served < nserve) && ((k % (gap + 1)) == gap);
         if (mem_ready) served++;
         mem_rdata = 64'h9E37_79B9_7F4A_7C15 * 64'(cyc + 3) ^ 64'(k);
         req_valid = (k == poke);
         req_size  = 2'b00;
         prev_rd   = mem_rdata;
         @(negedge clk);
         if (bus_ta && !bus_dval) check(1'b0, "R3 ta without dval", 1, 0);
         if (bus_ta && bus_tea)   check(1'b0, "R8 ta with tea", 1, 0);
         if (bus_dval) begin
            check(bus_data == prev_rd, "R11 beat data", bus_data, prev_rd);
            check(bus_dp == exp_par(bus_data), "R10 lane parity",
                  bus_dp, exp_par(bus_data));
            if (bus_ta && dv < 8) tam[dv] = 1'b1;
            dv++;
         end
         if (bus_tea) tea++;
      end
      mem_ready = 1'b0;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int dv, tea;
      logic [7:0] tam;
      // R1: outputs quiet during and just after reset
      repeat (3) @(negedge clk);
      check(!bus_dval && !bus_ta && !bus_tea, "R1 during reset",
            {bus_dval, bus_ta, bus_tea}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!bus_dval && !bus_ta && !bus_tea, "R1 after reset",
            {bus_dval, bus_ta, bus_tea}, 0);

      for (int v = 0; v < NV; v++) begin
         logic [23:0] e = VEC[v];
         run_xfer(e[23:22], e[21], int'(e[20:17]), int'(e[16:13]), -1, dv, tam, tea);
         // R2 beat count, R6 waits add none, R7 timeout
         check(dv == int'(e[12:9]), $sformatf("R2/R6 beats vec%0d", v), dv, e[12:9]);
         check(tam == e[8:1], $sformatf("%s ack mask vec%0d",
               e[23] ? "R5" : "R4", v), tam, e[8:1]);
         check(tea == int'(e[0]), $sformatf("R7 error count vec%0d", v), tea, e[0]);
      end

      // R9: request during a burst is dropped, not queued
      run_xfer(2'd2, 1'b0, 1, 15, 2, dv, tam, tea);
      check(dv == 4, "R9 beats with mid-transfer request", dv, 4);
      check(tam == 8'h0F, "R9 acks with mid-transfer request", tam, 8'h0F);
      check(tea == 0, "R9 no error after dropped request", tea, 0);

      // R9: idle sequencer ignores ready without a request
      repeat (4) begin
         @(negedge clk); mem_ready = 1'b1;
         @(negedge clk);
         check(!bus_dval && !bus_ta, "R9 idle ignores ready", {bus_dval, bus_ta}, 0);
      end
      mem_ready = 1'b0;

      // R1: reset mid-transfer clears strobes
      @(negedge clk); req_valid = 1'b1; req_size = 2'd2;
      @(negedge clk); req_valid = 1'b0; mem_ready = 1'b1;
      @(negedge clk); rst_n = 1'b0;
      #1ns;
      check(!bus_dval && !bus_ta && !bus_tea, "R1 reset mid-transfer",
            {bus_dval, bus_ta, bus_tea}, 0);
      @(negedge clk); rst_n = 1'b1; mem_ready = 1'b0;
      @(negedge clk);
      check(!bus_dval && !bus_ta && !bus_tea, "R1 quiet after re-reset",
            {bus_dval, bus_ta, bus_tea}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule